// File: doc/BRIEF.md
# Stepper Winding Duty-Cycle PWM Generator

This block drives the two active-low inhibit lines of a two-winding stepper driver. Each line is pulse-width modulated over a fixed window of 256 clock cycles, which is 32 us at 8 MHz. A 4-bit duty code per winding selects the share of the window during which that winding may conduct. The codes follow a sine profile in sixteenths of a half turn, so one set of codes serves full-step, half-step and the finer microstep modes.

Two over-current flags, one per winding and taken from external comparators, pass through a two-flop synchronizer. The flags may end the conducting part of a window early. This chopping is honoured only in full-step and half-step modes. In those modes the duty pairs are 100%/0% or 70.7%/70.7%, so cutting a window short does not change the ratio between the windings. In the finer modes the flags are ignored, so the microstep current ratio stays exact.

Top module: `winding_pwm_gen`

## Requirements
- R1: A free-running window counter counts 0 to 255 and wraps to 0, so every window lasts exactly 256 clock cycles.
- R2: Duty code k from 0 to 7 gives round(256·sin(k·π/16)) conducting cycles per window: 0, 50, 98, 142, 181, 213, 237 and 251. Every code from 8 to 15 gives all 256 cycles.
- R3: An output is high (winding allowed to conduct) from window cycle 0 for its conducting cycles, in one unbroken stretch. It is low (inhibited) for the rest of the window.
- R4: Synchronous reset clears the counter and all chop state and drives both outputs low from the first clock edge in reset. The first whole window after reset is released is fully inhibited, whatever codes are applied.
- R5: Duty codes and step mode are sampled only on the last cycle of a window. A change in the middle of a window leaves the rest of that window unchanged.
- R6: In full-step (mode 00) or half-step (mode 01), a high sense flag drives that winding's output low two clock edges after the flag rises. The output then stays low for the rest of the window, even if the flag falls.
- R7: Chop state is cleared at each window boundary. The next window follows its duty code again once the flag is low.
- R8: In quarter-step (mode 10) and eighth-step (mode 11), the sense flags have no effect on either output.
- R9: Permission to chop is taken from the mode sampled at the window boundary. Switching into full-step in the middle of a window does not allow chopping until the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz PWM clock |
| rst | input | 1 | Synchronous reset, active high |
| step_mode_i | input | 2 | 00 full, 01 half, 10 quarter, 11 eighth |
| duty_code_a_i | input | 4 | Duty code for winding A |
| duty_code_b_i | input | 4 | Duty code for winding B |
| sense_a_i | input | 1 | Over-current flag for winding A, asynchronous |
| sense_b_i | input | 1 | Over-current flag for winding B, asynchronous |
| inh_a_n_o | output | 1 | Inhibit for winding A, active low |
| inh_b_n_o | output | 1 | Inhibit for winding B, active low |

## Verification
All sixteen duty codes are swept on both windings at once, with the two codes kept complementary and changed in the middle of each window. Comparing every window cycle against the sine-derived count separates a wrong level or saturation from a late or partial code update. The sweep runs in the two fine modes with both flags toggling, so any leak from the sense path shows up as a shortened window. Windows in full-step and half-step place a flag pulse at chosen cycles, including a pulse shorter than the active stretch and a flag held across a boundary. These show the exact chop cycle, the latch holding after the flag falls, the release at the next boundary, and the delayed permission after a mode change in the middle of a window.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'b00,
    MODE_HALF    = 2'b01,
    MODE_QUARTER = 2'b10,
    MODE_EIGHTH  = 2'b11
  } step_mode_e;

  // Number of sine steps below the saturating code.
  localparam int unsigned SINE_STEPS = 8;

  // sin(k*pi/16) scaled to 256, rounded to nearest; k >= SINE_STEPS saturates.
  function automatic int unsigned sine_256(int unsigned k);
    case (k)
      0:       return 0;
      1:       return 50;
      2:       return 98;
      3:       return 142;
      4:       return 181;
      5:       return 213;
      6:       return 237;
      7:       return 251;
      default: return 256;
    endcase
  endfunction

  // Only modes whose duty pairs are 100/0 or 70.7/70.7 may chop.
  function automatic logic chop_permitted(step_mode_e m);
    return (m == MODE_FULL) || (m == MODE_HALF);
  endfunction

endpackage

// File: rtl/wpg_window_ctr.sv
module wpg_window_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = (cnt_q == LAST);

endmodule

// File: rtl/wpg_sense_sync.sv
module wpg_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else begin
      sh_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) sh_q[k] <= sh_q[k-1];
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/wpg_winding_chan.sv
module wpg_winding_chan
  import wpg_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int CODE_W = 4,
  localparam int ON_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              wrap_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              chop_en_i,
  input  logic              sense_i,
  output logic              inh_n_o,
  output logic [ON_W-1:0]   on_cyc_o,
  output logic              chop_o
);

  localparam int unsigned WIN = 1 << CNT_W;

  // Conducting cycles for a duty code, scaled from the 256-step sine profile.
  function automatic logic [ON_W-1:0] code_to_on(logic [CODE_W-1:0] c);
    int unsigned s;
    s = sine_256(32'(c));
    return ON_W'((s * WIN + 128) >> 8);
  endfunction

  logic [ON_W-1:0] on_q;
  logic            chop_q;
  logic            cut_now;

  assign cut_now = sense_i & chop_en_i;

  always_ff @(posedge clk) begin
    if (rst)         on_q <= '0;
    else if (wrap_i) on_q <= code_to_on(code_i);
  end

  always_ff @(posedge clk) begin
    if (rst)         chop_q <= 1'b0;
    else if (wrap_i) chop_q <= 1'b0;
    else             chop_q <= chop_q | cut_now;
  end

  assign inh_n_o  = ({1'b0, cnt_i} < on_q) & ~(chop_q | cut_now);
  assign on_cyc_o = on_q;
  assign chop_o   = chop_q;

endmodule

// File: rtl/winding_pwm_gen.sv
module winding_pwm_gen
  import wpg_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        step_mode_i,
  input  logic [CODE_W-1:0] duty_code_a_i,
  input  logic [CODE_W-1:0] duty_code_b_i,
  input  logic              sense_a_i,
  input  logic              sense_b_i,
  output logic              inh_a_n_o,
  output logic              inh_b_n_o
);

  localparam int N_WIND = 2;
  localparam int ON_W   = CNT_W + 1;

  logic [CNT_W-1:0]  win_cnt;
  logic              win_wrap;
  logic              chop_en_q;
  logic [N_WIND-1:0] sense_raw;
  logic [N_WIND-1:0] sense_sync;
  logic [N_WIND-1:0] chop_q;
  logic [N_WIND-1:0] inh_n;
  logic [CODE_W-1:0] code_arr [N_WIND];
  logic [ON_W-1:0]   on_cyc_q [N_WIND];

  assign sense_raw   = {sense_b_i, sense_a_i};
  assign code_arr[0] = duty_code_a_i;
  assign code_arr[1] = duty_code_b_i;

  wpg_window_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .cnt_o  (win_cnt),
    .wrap_o (win_wrap)
  );

  // Chop permission follows the mode sampled at the window boundary.
  always_ff @(posedge clk) begin
    if (rst)           chop_en_q <= 1'b0;
    else if (win_wrap) chop_en_q <= chop_permitted(step_mode_e'(step_mode_i));
  end

  for (genvar g = 0; g < N_WIND; g++) begin : g_wind
    wpg_sense_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (sense_raw[g]),
      .q_o (sense_sync[g])
    );

    wpg_winding_chan #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .cnt_i     (win_cnt),
      .wrap_i    (win_wrap),
      .code_i    (code_arr[g]),
      .chop_en_i (chop_en_q),
      .sense_i   (sense_sync[g]),
      .inh_n_o   (inh_n[g]),
      .on_cyc_o  (on_cyc_q[g]),
      .chop_o    (chop_q[g])
    );
  end

  assign inh_a_n_o = inh_n[0];
  assign inh_b_n_o = inh_n[1];

endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int CNT_W = 8,
  localparam int ON_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] win_cnt,
  input logic             win_wrap,
  input logic             chop_en_q,
  input logic [1:0]       chop_q,
  input logic [ON_W-1:0]  on_cyc [2],
  input logic             inh_a_n,
  input logic             inh_b_n
);

  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  // R4
  always @(negedge clk) begin
    if (rst_q) reset_inhibit_chk: assert (!inh_a_n && !inh_b_n);
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    win_wrap |=> (win_cnt == '0));

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !win_wrap |=> (win_cnt == $past(win_cnt) + 1'b1));

  // R5
  duty_a_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_wrap |=> $stable(on_cyc[0]));

  // R5
  duty_b_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !win_wrap |=> $stable(on_cyc[1]));

  // R3
  active_a_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    inh_a_n |-> ({1'b0, win_cnt} < on_cyc[0]));

  // R3
  active_b_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    inh_b_n |-> ({1'b0, win_cnt} < on_cyc[1]));

  // R6
  chop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (chop_q[0] && !win_wrap) |=> chop_q[0]);

  // R6
  chop_forces_low_chk: assert property (@(posedge clk) disable iff (rst)
    (chop_q != 2'b00) |-> !((chop_q[0] && inh_a_n) || (chop_q[1] && inh_b_n)));

  // R7
  chop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    win_wrap |=> (chop_q == 2'b00));

  // R8
  no_chop_when_barred_chk: assert property (@(posedge clk) disable iff (rst)
    !chop_en_q |-> (chop_q == 2'b00));

endmodule

bind winding_pwm_gen wpg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win_cnt   (win_cnt),
  .win_wrap  (win_wrap),
  .chop_en_q (chop_en_q),
  .chop_q    (chop_q),
  .on_cyc    (on_cyc_q),
  .inh_a_n   (inh_a_n_o),
  .inh_b_n   (inh_b_n_o)
);

// File: tb/sim_winding_pwm_gen.sv
module sim_winding_pwm_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b10;
  logic [3:0] ca = 4'd0;
  logic [3:0] cb = 4'd15;
  logic       sa = 1'b0;
  logic       sb = 1'b0;
  logic       inh_a, inh_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  winding_pwm_gen u0 (
    .clk           (clk),
    .rst           (rst),
    .step_mode_i   (mode),
    .duty_code_a_i (ca),
    .duty_code_b_i (cb),
    .sense_a_i     (sa),
    .sense_b_i     (sb),
    .inh_a_n_o     (inh_a),
    .inh_b_n_o     (inh_b)
  );

  function automatic int exp_on(int k);
    if (k >= 8) return 256;
    return $rtoi(256.0 * $sin(k * 3.14159265358979 / 16.0) + 0.5);
  endfunction

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One window from counter value 0; chop index = first forced-low cycle.
  task automatic run_window(int ea, int eb, int cha, int chb,
                            int sa_on, int sa_off, int sb_on, int sb_off,
                            logic [3:0] na, logic [3:0] nb, logic [1:0] nm,
                            string tag_a, string tag_b);
    int bad_a = 0, bad_b = 0, hi_a = 0, hi_b = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (i == sa_on)  sa = 1'b1;
      if (i == sa_off) sa = 1'b0;
      if (i == sb_on)  sb = 1'b1;
      if (i == sb_off) sb = 1'b0;
      if (i == 100) begin ca = na; cb = nb; mode = nm; end
      if (inh_a !== ((i < ea) && (i < cha))) bad_a++;
      if (inh_b !== ((i < eb) && (i < chb))) bad_b++;
      if (inh_a === 1'b1) hi_a++;
      if (inh_b === 1'b1) hi_b++;
    end
    check(bad_a == 0, tag_a, hi_a, imin(ea, cha));
    check(bad_b == 0, tag_b, hi_b, imin(eb, chb));
  endtask

  initial begin
    int low_bad;
    repeat (3) @(negedge clk);
    // R4: outputs inhibited during reset
    check(inh_a === 1'b0, "R4 reset A", int'(inh_a), 0);
    check(inh_b === 1'b0, "R4 reset B", int'(inh_b), 0);

    // R4: first window after release fully inhibited
    @(negedge clk);
    rst = 1'b0;
    low_bad = 0;
    for (int i = 0; i < 256; i++) begin
      if (i > 0) @(negedge clk);
      if (inh_a !== 1'b0 || inh_b !== 1'b0) low_bad++;
    end
    check(low_bad == 0, "R4 first window inhibited", low_bad, 0);

    // R1 R2 R3 R5 R8: full code sweep in fine modes, flags toggling
    for (int w = 0; w < 16; w++) begin
      logic [3:0] na, nb;
      logic [1:0] nm;
      if (w == 15) begin
        na = 4'd4; nb = 4'd4; nm = 2'b01;
      end else begin
        na = 4'(w + 1); nb = 4'(14 - w); nm = 2'(2 + ((w + 1) % 2));
      end
      run_window(exp_on(w), exp_on(15 - w), 256, 256, 20, 200, 40, 220,
                 na, nb, nm, "R2/R3/R5/R8 sweep A", "R2/R3/R5/R8 sweep B");
    end

    // R6: half-step chop on A, flag pulse shorter than the active part
    run_window(181, 181, 52, 256, 50, 60, -1, -1, 4'd8, 4'd0, 2'b00,
               "R6 half chop A", "R6 half unchopped B");
    // R6: full-step chop late in a 100% window
    run_window(256, 0, 202, 256, 200, 230, 30, 31, 4'd4, 4'd4, 2'b01,
               "R6 full chop A", "R6 full zero B");
    // R7: chop released at the boundary
    run_window(181, 181, 256, 256, -1, -1, -1, -1, 4'd4, 4'd4, 2'b10,
               "R7 release A", "R7 release B");
    // R9: mode switched to full mid-window while the flag rises: no chop yet
    run_window(181, 181, 256, 256, 100, -1, -1, -1, 4'd4, 4'd4, 2'b00,
               "R9 late mode A", "R9 late mode B");
    // R9 R6: next window chops from cycle 0, latch holds after flag drops
    run_window(181, 181, 0, 256, -1, 10, -1, -1, 4'd4, 4'd4, 2'b00,
               "R9/R6 chop from start A", "R9 unaffected B");
    // R7: normal again
    run_window(181, 181, 256, 256, -1, -1, -1, -1, 4'd4, 4'd4, 2'b00,
               "R7 recover A", "R7 recover B");

    // R4: reset in mid-window
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(inh_a === 1'b0, "R4 mid reset A", int'(inh_a), 0);
    check(inh_b === 1'b0, "R4 mid reset B", int'(inh_b), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule